// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate with Rounding and Saturation

This block is the arithmetic core of a filter inner loop. On each enabled cycle it multiplies two signed fractional operands and then does one of four things with the accumulator: sets it to zero, loads the product into it, adds the product or subtracts the product. Operands are fractions in the range -1 <= x < 1, with the radix point just after the sign bit. The product is shifted left by one so that it carries a single sign bit. The accumulator holds extra guard bits above the product, so a run of partial sums can go past the output range and come back without losing information.

A separate store path turns the accumulator into a result as wide as memory. It drops the low bits with one of three rounding modes (truncation, round-half-up, round-half-to-even) and then clamps the rounded value to the most positive or most negative output code. A sticky overflow flag records that a store had to clamp. Software runs a loop of accumulate steps and then requests a store. The stored word arrives one cycle later.

Top module: `fxp_mac`

## Requirements
- R1: The product of operands `a` and `b` is a*b*2, held with 2*OP_W bits: a signed fraction with one sign bit and 2*OP_W-1 fraction bits. When both operands are the most negative code, the product is the largest positive product, 2^(2*OP_W-1)-1.
- R2: When `en` is high, `op` acts at the clock edge. The codes are 0 = clear to zero, 1 = load the product, 2 = add the product, 3 = subtract the product. When `en` is low, the accumulator keeps its value whatever `op`, `a` and `b` are.
- R3: The accumulator is 2*OP_W+GUARD_W bits wide and wraps modulo 2^(2*OP_W+GUARD_W). Partial sums that leave the output range and come back lose nothing.
- R4: `rnd` = 0 or 3 selects truncation. The low 2*OP_W-OUT_W accumulator bits are dropped, which rounds toward minus infinity.
- R5: `rnd` = 1 selects round-to-nearest. One half of an output LSB is added before the low bits are dropped, so an exact half rounds up.
- R6: `rnd` = 2 selects convergent rounding. A remainder above one half rounds up and a remainder below one half rounds down. An exact half rounds to the neighbour whose LSB is zero.
- R7: Saturation is checked after rounding. A rounded value above 2^(OUT_W-1)-1 is stored as that value, and one below -2^(OUT_W-1) is stored as -2^(OUT_W-1). Values are never wrapped.
- R8: `ovf` is 0 after reset. It goes to 1 in the cycle after a store that clamps, and it stays 1 until an enabled clear. A clear in the same cycle as a clamping store leaves it 0.
- R9: A store request samples the accumulator as it was before that edge's operation. `res` shows the result after the next edge, with `res_valid` high for exactly that one cycle. `res` holds its value between stores and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enables the accumulator operation this cycle |
| op | input | 2 | Accumulator operation: 0 clear, 1 load, 2 add, 3 subtract |
| a | input | OP_W | Signed fractional operand |
| b | input | OP_W | Signed fractional operand |
| st_req | input | 1 | Store request; samples the current accumulator |
| rnd | input | 2 | Rounding mode: 0/3 truncate, 1 nearest, 2 convergent |
| res | output | OUT_W | Rounded and saturated stored result |
| res_valid | output | 1 | High for the one cycle in which a new result is shown |
| ovf | output | 1 | Sticky flag: a store saturated since the last clear |

## Verification
An operation presented before edge k changes the accumulator at edge k. A store presented before edge k+1 sees that value, and `res`, `res_valid` and `ovf` change at edge k+1. A store and an operation presented in the same cycle therefore show the accumulator as it was before that operation. The reference model in the bench applies the store first and then the operation, both at the rising edge. It compares all three outputs at the following falling edge, one cycle after each request. The directed corner values (exact halves, negative halves, the product of the two most negative operands, and sums past the output range) are read at that same falling edge.

// File: rtl/fxp_mac_pkg.sv
// Shared encodings for the fixed-point MAC.
// Assumes: 2-bit op and rounding-mode fields as listed in the brief.
package fxp_mac_pkg;
    typedef enum logic [1:0] {
        MAC_CLEAR = 2'd0,
        MAC_LOAD  = 2'd1,
        MAC_ADD   = 2'd2,
        MAC_SUB   = 2'd3
    } mac_op_e;

    typedef enum logic [1:0] {
        RND_TRUNC     = 2'd0,
        RND_NEAREST   = 2'd1,
        RND_CONV      = 2'd2,
        RND_TRUNC_ALT = 2'd3
    } rnd_mode_e;
endpackage

// File: rtl/frac_mult.sv
// Signed fractional multiplier.
// Gives a*b aligned to one sign bit (shifted left by one).
// Assumes: both operands are signed fractions of OP_W bits. The single
// overflowing case, most-negative times most-negative, is clamped.
module frac_mult #(
    parameter int OP_W = 16
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] prod
);
    localparam int PROD_W = 2 * OP_W;
    localparam logic [PROD_W-1:0] PROD_MAX = {1'b0, {(PROD_W-1){1'b1}}};
    localparam logic [OP_W-1:0]   OP_MIN   = {1'b1, {(OP_W-1){1'b0}}};

    logic signed [PROD_W-1:0] full;
    logic                     both_min;

    // Full-width signed product and detection of the one overflowing case.
    always_comb begin
        full     = $signed(a) * $signed(b);
        both_min = (a == OP_MIN) && (b == OP_MIN);
    end

    // Remove the duplicated sign bit, or clamp the overflowing case.
    always_comb begin
        if (both_min) prod = PROD_MAX;
        else          prod = PROD_W'(full << 1);
    end
endmodule

// File: rtl/mac_accum.sv
// Guard-bit accumulator register.
// Clears, loads, adds or subtracts the product on enabled cycles.
// Assumes: the product is signed PROD_W bits and is sign-extended to ACC_W.
// The sum wraps modulo 2^ACC_W.
module mac_accum #(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        op,
    input  logic [PROD_W-1:0] prod,
    output logic [ACC_W-1:0]  acc
);
    import fxp_mac_pkg::*;

    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_nxt;

    // Sign-extend the product to the accumulator width.
    always_comb prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

    // Pick the next accumulator value from the operation code.
    always_comb begin
        acc_nxt = acc;
        if (en) begin
            case (mac_op_e'(op))
                MAC_CLEAR: acc_nxt = '0;
                MAC_LOAD:  acc_nxt = prod_ext;
                MAC_ADD:   acc_nxt = acc + prod_ext;
                MAC_SUB:   acc_nxt = acc - prod_ext;
                default:   acc_nxt = acc;
            endcase
        end
    end

    // Accumulator register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc_nxt;
    end
endmodule

// File: rtl/store_round.sv
// Store-path narrowing.
// Rounds the accumulator by dropping DROP low bits under the selected
// mode, then saturates to OUT_W bits.
// Assumes: DROP >= 2 and ACC_W+1-DROP >= OUT_W. Purely combinational.
module store_round #(
    parameter int ACC_W = 40,
    parameter int DROP  = 16,
    parameter int OUT_W = 16
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [1:0]       mode,
    output logic [OUT_W-1:0] res,
    output logic             sat
);
    import fxp_mac_pkg::*;

    localparam int KEEP_W = ACC_W + 1 - DROP;
    localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [ACC_W:0]          ext;
    logic [KEEP_W-1:0]       kept;
    logic                    half_bit;
    logic                    below_half;
    logic                    round_up;
    logic [KEEP_W-1:0]       rounded;
    logic [KEEP_W-OUT_W:0]   upper;
    logic                    fits;

    // Split the accumulator, with one extra sign bit, into kept and dropped parts.
    always_comb begin
        ext        = {acc[ACC_W-1], acc};
        kept       = ext[ACC_W:DROP];
        half_bit   = acc[DROP-1];
        below_half = |acc[DROP-2:0];
    end

    // Decide whether the rounding mode increments the kept part.
    always_comb begin
        case (rnd_mode_e'(mode))
            RND_NEAREST: round_up = half_bit;
            RND_CONV:    round_up = half_bit & (below_half | kept[0]);
            default:     round_up = 1'b0;
        endcase
        rounded = kept + KEEP_W'(round_up);
    end

    // Saturate after rounding: the upper bits must all equal the sign.
    always_comb begin
        upper = rounded[KEEP_W-1:OUT_W-1];
        fits  = (&upper) | ~(|upper);
        sat   = ~fits;
        if (fits)                      res = rounded[OUT_W-1:0];
        else if (rounded[KEEP_W-1])    res = OUT_MIN;
        else                           res = OUT_MAX;
    end
endmodule

// File: rtl/fxp_mac.sv
// Fixed-point multiply-accumulate with rounding and saturating store.
// Multiplier and accumulator act on enabled cycles. A store request
// registers the rounded, saturated accumulator one cycle later and
// updates the sticky overflow flag.
// Assumes: OUT_W <= 2*OP_W-2 so that at least two bits are dropped.
module fxp_mac #(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 8,
    parameter int OUT_W   = OP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       op,
    input  logic [OP_W-1:0]  a,
    input  logic [OP_W-1:0]  b,
    input  logic             st_req,
    input  logic [1:0]       rnd,
    output logic [OUT_W-1:0] res,
    output logic             res_valid,
    output logic             ovf
);
    import fxp_mac_pkg::*;

    localparam int PROD_W = 2 * OP_W;
    localparam int ACC_W  = PROD_W + GUARD_W;
    localparam int DROP   = PROD_W - OUT_W;

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  acc;
    logic [OUT_W-1:0]  st_val;
    logic              st_sat;
    logic              do_clear;

    frac_mult #(.OP_W(OP_W)) u_mult (
        .a    (a),
        .b    (b),
        .prod (prod)
    );

    mac_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .op    (op),
        .prod  (prod),
        .acc   (acc)
    );

    store_round #(.ACC_W(ACC_W), .DROP(DROP), .OUT_W(OUT_W)) u_store (
        .acc  (acc),
        .mode (rnd),
        .res  (st_val),
        .sat  (st_sat)
    );

    // An enabled clear also resets the sticky flag.
    always_comb do_clear = en && (mac_op_e'(op) == MAC_CLEAR);

    // Result register: loads on a store request, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= st_req;
            if (st_req) res <= st_val;
        end
    end

    // Sticky overflow flag: set by a clamping store, cleared by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf <= 1'b0;
        else if (do_clear)         ovf <= 1'b0;
        else if (st_req && st_sat) ovf <= 1'b1;
    end
endmodule

// File: rtl/fxp_mac_chk.sv
// Port-level protocol checker for fxp_mac, attached by bind.
// Assumes: the same OUT_W as the bound instance.
module fxp_mac_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [1:0]       op,
    input logic             st_req,
    input logic [OUT_W-1:0] res,
    input logic             res_valid,
    input logic             ovf
);
    localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    // R9: a store request yields a valid result on the next cycle.
    a_r9_store_valid: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |=> res_valid);

    // R9: a valid result only follows a store request.
    a_r9_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(st_req));

    // R9: the result holds when no store was requested.
    a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_req |=> $stable(res));

    // R8: an enabled clear leaves the flag low.
    a_r8_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 2'd0) |=> !ovf);

    // R8: the flag stays set until a clear.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(en && op == 2'd0)) |=> ovf);

    // R7: a newly raised flag comes with a clamped extreme result.
    a_r7_rise_extreme: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (res_valid && (res == OUT_MAX || res == OUT_MIN)));
endmodule

bind fxp_mac fxp_mac_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .op        (op),
    .st_req    (st_req),
    .res       (res),
    .res_valid (res_valid),
    .ovf       (ovf)
);

// File: tb/fxp_mac_test.sv
// Self-checking bench: behavioural reference model compared every clock,
// plus directed corner values.
module fxp_mac_test;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 16;
    localparam int G     = 8;
    localparam int ACC_W = 2 * W + G;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         st_req = 1'b0;
    logic [1:0]   rnd = 2'd0;
    logic [W-1:0] res;
    logic         res_valid;
    logic         ovf;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    live = 0;
    string cur_tag = "R2";

    longint m_acc = 0;
    longint m_res = 0;
    bit     m_valid = 0;
    bit     m_ovf = 0;

    fxp_mac #(.OP_W(W), .GUARD_W(G), .OUT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
        .st_req(st_req), .rnd(rnd), .res(res), .res_valid(res_valid), .ovf(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint f_prod(longint x, longint y);
        if (x == -32768 && y == -32768) return 64'sd2147483647;
        return x * y * 2;
    endfunction

    function automatic longint f_wrap(longint x);
        longint m;
        m = x & ((64'sd1 <<< ACC_W) - 1);
        if (((m >>> (ACC_W - 1)) & 1) == 1) m = m - (64'sd1 <<< ACC_W);
        return m;
    endfunction

    function automatic longint f_store(longint acc, int mode, output bit sat);
        longint q, low;
        q   = acc >>> W;
        low = acc & 64'hFFFF;
        if (mode == 1 && low >= 32768) q = q + 1;
        if (mode == 2 && (low > 32768 || (low == 32768 && (q & 1) == 1))) q = q + 1;
        sat = 0;
        if (q > 32767)  begin q = 32767;  sat = 1; end
        if (q < -32768) begin q = -32768; sat = 1; end
        return q;
    endfunction

    // Reference model: store sees the old accumulator, then the operation.
    always @(posedge clk) begin
        bit     s;
        longint p;
        if (!rst_n) begin
            m_acc = 0; m_res = 0; m_valid = 0; m_ovf = 0;
        end else begin
            m_valid = st_req;
            if (st_req) begin
                m_res = f_store(m_acc, int'(rnd), s);
                if (s) m_ovf = 1;
            end
            p = f_prod(longint'($signed(a)), longint'($signed(b)));
            if (en) begin
                case (op)
                    2'd0: begin m_acc = 0; m_ovf = 0; end
                    2'd1: m_acc = f_wrap(p);
                    2'd2: m_acc = f_wrap(m_acc + p);
                    default: m_acc = f_wrap(m_acc - p);
                endcase
            end
        end
    end

    task automatic chk(string tag, longint act, longint exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Clock-by-clock comparison against the model.
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk(cur_tag, longint'(res_valid), longint'(m_valid), "res_valid (R9)");
            chk(cur_tag, longint'(ovf), longint'(m_ovf), "ovf (R8)");
            chk(cur_tag, longint'($signed(res)), m_res, "res");
        end
    end

    task automatic step(bit e, int o, longint x, longint y, bit s, int m);
        en = e; op = 2'(o); a = W'(x); b = W'(y); st_req = s; rnd = 2'(m);
        @(negedge clk);
        en = 0; st_req = 0;
    endtask

    // Load x*y, store with mode m, and compare with a worked value.
    task automatic load_store(string tag, longint x, longint y, int m, longint exp);
        step(1, 1, x, y, 0, 0);
        step(0, 0, 0, 0, 1, m);
        chk(tag, longint'($signed(res)), exp, "directed result");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", longint'(res), 0, "reset res");
        chk("R9", longint'(res_valid), 0, "reset res_valid");
        chk("R8", longint'(ovf), 0, "reset ovf");
        rst_n = 1; live = 1;
        @(negedge clk);

        cur_tag = "R1";
        load_store("R1", 16384, 16384, 0, 8192);
        load_store("R1", -32768, -32768, 0, 32767);
        chk("R1", longint'(ovf), 0, "min*min truncated has no overflow");
        load_store("R1", -32768, 32767, 0, -32767);

        cur_tag = "R4";
        load_store("R4", 16384, 1, 0, 0);
        load_store("R4", 16384, -1, 0, -1);
        load_store("R4", 16384, 3, 3, 1);
        cur_tag = "R5";
        load_store("R5", 16384, 1, 1, 1);
        load_store("R5", 16384, -1, 1, 0);
        load_store("R5", 16384, 5, 1, 3);
        cur_tag = "R6";
        load_store("R6", 16384, 1, 2, 0);
        load_store("R6", 16384, 3, 2, 2);
        load_store("R6", 16384, 5, 2, 2);
        load_store("R6", 16384, -1, 2, 0);
        load_store("R6", 16385, 1, 2, 1);

        cur_tag = "R2";
        step(1, 1, 16384, 16384, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        chk("R2", longint'($signed(res)), 8192, "disabled clear ignored");
        step(1, 2, 16384, 16384, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        chk("R2", longint'($signed(res)), 16384, "add");
        step(1, 3, 16384, 16384, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        chk("R2", longint'($signed(res)), 8192, "subtract");
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        chk("R2", longint'($signed(res)), 0, "clear");

        cur_tag = "R3";
        for (int i = 0; i < 3; i++) step(1, 2, 32767, 32767, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        chk("R7", longint'($signed(res)), 32767, "positive clamp");
        chk("R8", longint'(ovf), 1, "flag set by clamp");
        for (int i = 0; i < 3; i++) step(1, 3, 32767, 32767, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        chk("R3", longint'($signed(res)), 0, "guard bits recover");
        chk("R8", longint'(ovf), 1, "flag sticky");
        step(1, 0, 0, 0, 0, 0);
        chk("R8", longint'(ovf), 0, "flag cleared");

        cur_tag = "R7";
        step(1, 3, 32767, 32767, 0, 0);
        step(1, 3, 32767, 32767, 0, 0);
        step(0, 0, 0, 0, 1, 1);
        chk("R7", longint'($signed(res)), -32768, "negative clamp");
        chk("R8", longint'(ovf), 1, "flag set by negative clamp");

        cur_tag = "R9";
        step(1, 1, 16384, 16384, 0, 0);
        step(1, 1, 8192, 16384, 1, 0);
        chk("R9", longint'($signed(res)), 8192, "store sees old accumulator");
        chk("R9", longint'(res_valid), 1, "valid pulse");
        step(0, 0, 0, 0, 0, 0);
        chk("R9", longint'(res_valid), 0, "valid single cycle");
        chk("R9", longint'($signed(res)), 8192, "result held");

        cur_tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step(r < 70, (r < 3) ? 0 : int'($urandom_range(1, 3)),
                 longint'($signed(W'($urandom))), longint'($signed(W'($urandom))),
                 $urandom_range(0, 3) == 0, int'($urandom_range(0, 3)));
        end

        step(0, 0, 0, 0, 0, 0);
        live = 0;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule